// File: doc/BRIEF.md
# Discrete I/O Channel with Pin History

This block turns one chip pin into a host-controlled discrete channel. The host drives it through a small register port: a control word (edge selection and interrupt enable), a sampling period, a read-only 16-bit pin history, and a command word. The command word holds a 2-bit request code and a 2-bit mode code. As an output, the channel drives the pin high or low on command. As an input, it records the pin level on selected edges, at a fixed period measured on an internal free-running timebase, or once per host read request.

Every recording shifts the history right by one place and puts the new value in the top bit. When interrupts are enabled, each recording raises a one-cycle interrupt pulse. Periodic sampling keeps its own schedule: each compare time is the previous compare time plus the period, so service timing never accumulates drift. The pin input passes through a two-flop synchronizer before it is sampled or checked for edges.

Register map (2-bit address): 0 = control ([1:0] edge select, [2] interrupt enable), 1 = period, 2 = history (read only), 3 = command ([1:0] request code, [3:2] mode code). Register reads are combinational on the address. Every interface here is a plain control pin, so no valid/ready back-pressure applies.

Top module: `dio_channel`

## Requirements
- R1: Each recording shifts the 16-bit history right by one and places the new value in bit 15; the old bit 0 is lost. Sixteen alternating drives that end low leave 0x5555.
- R2: Request code 01 makes the pin an output driven high and records 1. Request code 10 makes it an output driven low and records 0. The mode code has no effect on either.
- R3: Request code 11 with mode 00 selects transition mode and records the synchronized level. Edge select 00 records nothing, 01 records rising edges, 10 records falling edges and 11 records both. A change on the pin is recorded at the third clock edge after it reaches the input.
- R4: Request code 11 with mode 01 selects periodic mode and records the level. The first match comes P cycles after that service edge, where P is the period, and each later match comes P cycles after the previous one. Each match records the synchronized level.
- R5: Request code 11 with mode 10 records a single value and changes neither the direction nor the mode. While the channel is an output, the value recorded is the output latch, not the pad.
- R6: A request that is being serviced in the same cycle as a selected edge or a match wins. The edge or match is then not recorded, but the periodic schedule still advances.
- R7: When control bit 2 is set, every recording pulses rec_irq for one cycle. When it is clear, recordings still happen but no pulse is produced.
- R8: After reset the pin is an input (pin_oe low), the history is 0 and the command reads 0. While the channel is an output, pin edges and matches record nothing, and only a request code 11 returns the channel to input.
- R9: A request written to the command register is serviced on the next clock edge. After that edge the request field reads back 00.
- R10: Request code 11 with mode 11 does nothing: the history, the direction and the interrupt stay untouched, and the request field is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| pin_in | input | 1 | Pad level (asynchronous) |
| pin_out | output | 1 | Output latch level |
| pin_oe | output | 1 | Output enable, high while the channel is an output |
| hist_o | output | 16 | Pin history, newest value in bit 15 |
| rec_irq | output | 1 | One-cycle pulse per recording when enabled |

## Verification
The channel is tried with four kinds of stimulus:
- Long alternating drive sequences. These separate a right shift from a left shift or a wrong insertion bit.
- Square waves on the pin under each edge select. The all-ones, all-zeros and 0x5555 patterns separate the rising, falling and either-edge decoding.
- A fixed period in periodic mode. The spacing between interrupt pulses separates scheduling from the previous compare time from scheduling relative to service, and from off-by-one periods.
- A read request that lands on the same edge as a pin change. It shows that only one value is recorded. Reads taken while the channel is an output, with the pad held opposite, separate latch sampling from pad sampling.

// File: rtl/dio_pkg.sv
package dio_pkg;
  typedef enum logic [1:0] {CH_IDLE, CH_OUT, CH_EDGE, CH_MATCH} ch_state_e;

  localparam logic [1:0] REQ_NONE = 2'b00;
  localparam logic [1:0] REQ_HIGH = 2'b01;
  localparam logic [1:0] REQ_LOW  = 2'b10;
  localparam logic [1:0] REQ_INIT = 2'b11;

  localparam logic [1:0] MODE_EDGE  = 2'b00;
  localparam logic [1:0] MODE_MATCH = 2'b01;
  localparam logic [1:0] MODE_READ  = 2'b10;
  localparam logic [1:0] MODE_RSVD  = 2'b11;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_RATE = 2'd1;
  localparam logic [1:0] ADDR_HIST = 2'd2;
  localparam logic [1:0] ADDR_CMD  = 2'd3;

  typedef struct packed {
    logic       irq_en;
    logic [1:0] edge_sel;   // bit0 rising, bit1 falling
  } ctrl_t;
endpackage

// File: rtl/dio_sync_edge.sv
module dio_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], pin_in};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/dio_match_sched.sv
module dio_match_sched #(
  parameter int TB_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            advance,
  input  logic [TB_W-1:0] rate,
  output logic            hit
);
  logic [TB_W-1:0] tb;
  logic [TB_W-1:0] cmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb  <= '0;
      cmp <= '0;
    end else begin
      tb <= tb + 1'b1;
      if (arm)          cmp <= tb + rate;
      else if (advance) cmp <= cmp + rate;
    end
  end

  assign hit = (tb == cmp);
endmodule

// File: rtl/dio_hist_shift.sv
module dio_hist_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] hist
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= {bit_in, hist[W-1:1]};
  end
endmodule

// File: rtl/dio_channel.sv
module dio_channel #(
  parameter int HIST_W      = 16,
  parameter int TB_W        = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic [HIST_W-1:0] hist_o,
  output logic              rec_irq
);
  import dio_pkg::*;

  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t           ctrl_q;
  logic [TB_W-1:0] rate_q;
  logic [1:0]      cmd_pend, cmd_mode;
  ch_state_e       state_q, state_n;
  logic            out_lvl, out_lvl_n;
  logic            lvl, rise, fall, hit;
  logic            rec, rec_bit, arm, adv;
  logic            host_req, edge_evt, match_evt, cmd_wr;

  dio_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  dio_match_sched #(.TB_W(TB_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .arm(arm), .advance(adv),
    .rate(rate_q), .hit(hit)
  );

  dio_hist_shift #(.W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(rec), .bit_in(rec_bit),
    .hist(hist_o)
  );

  assign cmd_wr    = reg_wr && (reg_addr == ADDR_CMD);
  assign host_req  = (cmd_pend != REQ_NONE);
  assign edge_evt  = (state_q == CH_EDGE) &&
                     ((rise && ctrl_q.edge_sel[0]) || (fall && ctrl_q.edge_sel[1]));
  assign match_evt = (state_q == CH_MATCH) && hit;

  always_comb begin
    rec       = 1'b0;
    rec_bit   = 1'b0;
    arm       = 1'b0;
    adv       = 1'b0;
    state_n   = state_q;
    out_lvl_n = out_lvl;
    if (host_req) begin
      adv = match_evt;  // keep periodic schedule even when the sample is dropped
      unique case (cmd_pend)
        REQ_HIGH: begin state_n = CH_OUT; out_lvl_n = 1'b1; rec = 1'b1; rec_bit = 1'b1; end
        REQ_LOW:  begin state_n = CH_OUT; out_lvl_n = 1'b0; rec = 1'b1; rec_bit = 1'b0; end
        default: begin
          unique case (cmd_mode)
            MODE_EDGE:  begin state_n = CH_EDGE; rec = 1'b1; rec_bit = lvl; end
            MODE_MATCH: begin state_n = CH_MATCH; arm = 1'b1; adv = 1'b0;
                              rec = 1'b1; rec_bit = lvl; end
            MODE_READ:  begin rec = 1'b1; rec_bit = (state_q == CH_OUT) ? out_lvl : lvl; end
            default:    ;
          endcase
        end
      endcase
    end else if (edge_evt) begin
      rec = 1'b1; rec_bit = lvl;
    end else if (match_evt) begin
      rec = 1'b1; rec_bit = lvl; adv = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      rate_q   <= '0;
      cmd_pend <= REQ_NONE;
      cmd_mode <= MODE_EDGE;
      state_q  <= CH_IDLE;
      out_lvl  <= 1'b0;
      rec_irq  <= 1'b0;
    end else begin
      state_q <= state_n;
      out_lvl <= out_lvl_n;
      rec_irq <= rec && ctrl_q.irq_en;
      if (reg_wr && reg_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (reg_wr && reg_addr == ADDR_RATE) rate_q <= reg_wdata[TB_W-1:0];
      if (cmd_wr) begin
        cmd_pend <= reg_wdata[1:0];
        cmd_mode <= reg_wdata[3:2];
      end else if (host_req) begin
        cmd_pend <= REQ_NONE;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
      ADDR_RATE: reg_rdata[TB_W-1:0]   = rate_q;
      ADDR_HIST: reg_rdata[HIST_W-1:0] = hist_o;
      default:   reg_rdata[3:0]        = {cmd_mode, cmd_pend};
    endcase
  end

  assign pin_oe  = (state_q == CH_OUT);
  assign pin_out = out_lvl;
endmodule

// File: rtl/dio_channel_chk.sv
module dio_channel_chk #(
  parameter int HIST_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cmd_pend,
  input logic [1:0]        cmd_mode,
  input logic              cmd_wr,
  input logic [HIST_W-1:0] hist_o,
  input logic              rec_irq,
  input logic              pin_oe,
  input logic              pin_out
);
  a_r1_shift_right: assert property (@(posedge clk) disable iff (!rst_n)
    rec_irq |-> hist_o[HIST_W-2:0] == $past(hist_o[HIST_W-1:1]));

  a_r2_drive_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pend == 2'b01) |=> (pin_oe && pin_out && hist_o[HIST_W-1]));

  a_r2_drive_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pend == 2'b10) |=> (pin_oe && !pin_out && !hist_o[HIST_W-1]));

  a_r8_oe_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_oe) |-> $past(cmd_pend == 2'b01 || cmd_pend == 2'b10));

  a_r9_req_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pend != 2'b00 && !cmd_wr) |=> (cmd_pend == 2'b00));

  a_r10_rsvd_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pend == 2'b11 && cmd_mode == 2'b11) |=> ($stable(hist_o) && !rec_irq && $stable(pin_oe)));
endmodule

bind dio_channel dio_channel_chk #(.HIST_W(HIST_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_pend(cmd_pend), .cmd_mode(cmd_mode),
  .cmd_wr(cmd_wr), .hist_o(hist_o), .rec_irq(rec_irq),
  .pin_oe(pin_oe), .pin_out(pin_out)
);

// File: tb/test_dio_channel.sv
module test_dio_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        pin_in = 1'b0;
  logic        pin_out, pin_oe, rec_irq;
  logic [15:0] hist_o;

  int n_cmp = 0, n_bad = 0, irq_cnt = 0;
  longint cyc = 0, irq_last = 0, irq_prev = 0;
  logic [15:0] model = '0;
  logic [15:0] exp_q[$];
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dio_channel i_dio_channel (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .hist_o(hist_o), .rec_irq(rec_irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_rec(input logic b);
    model = {b, model[15:1]};
    exp_q.push_back(model);
  endtask

  // monitor: pops one expected history per interrupt pulse
  always @(negedge clk) begin
    if (rst_n && rec_irq) begin
      irq_cnt++;
      irq_prev = irq_last;
      irq_last = cyc;
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R7 unexpected record: actual %h expected none", hist_o);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if (hist_o !== e) begin
          n_bad++;
          $display("FAIL R1 history: actual %h expected %h", hist_o, e);
        end
      end
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic issue(input logic [1:0] code, input logic [1:0] mode);
    logic [15:0] d;
    reg_write(2'd3, {12'b0, mode, code});
    reg_read(2'd3, d);
    check(d[1:0], code, "R9 request pending before service");
    @(negedge clk);
    reg_read(2'd3, d);
    check(d[1:0], 2'b00, "R9 request field cleared");
    repeat (2) @(negedge clk);
  endtask

  task automatic toggle(input logic rec_on_rise, input logic rec_on_fall);
    @(negedge clk);
    pin_in = ~pin_in;
    if ((pin_in && rec_on_rise) || (!pin_in && rec_on_fall)) expect_rec(pin_in);
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_irq(input int base);
    for (int i = 0; i < 300 && irq_cnt <= base; i++) @(negedge clk);
  endtask

  initial begin
    logic [15:0] d;
    int base;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(pin_oe, 1'b0, "R8 pin_oe after reset");
    check(hist_o, 16'h0, "R8 history after reset");
    reg_read(2'd3, d);
    check(d, 16'h0, "R8 command after reset");
    rst_n = 1'b1;
    reg_write(2'd0, 16'h0004);

    // R2 drives; mode code must be ignored
    expect_rec(1'b1); issue(2'b01, 2'b11);
    check({pin_oe, pin_out}, 2'b11, "R2 drive high with mode 11");
    expect_rec(1'b0); issue(2'b10, 2'b01);
    check({pin_oe, pin_out}, 2'b10, "R2 drive low with mode 01");
    for (int i = 0; i < 16; i++) begin
      expect_rec(~i[0]); issue(i[0] ? 2'b10 : 2'b01, 2'b00);
    end
    check(hist_o, 16'h5555, "R1 alternating drives");

    // R5 read while output records latch, not pad
    expect_rec(1'b1); issue(2'b01, 2'b00);
    pin_in = 1'b0;
    expect_rec(1'b1); issue(2'b11, 2'b10);
    check(pin_oe, 1'b1, "R5 read keeps output direction");

    // R8 edges ignored while output
    base = irq_cnt;
    for (int i = 0; i < 4; i++) toggle(1'b0, 1'b0);
    check(irq_cnt, base, "R8 edges ignored as output");

    // R3 either edge
    reg_write(2'd0, 16'h0007);
    pin_in = 1'b0; repeat (4) @(negedge clk);
    expect_rec(1'b0); issue(2'b11, 2'b00);
    check(pin_oe, 1'b0, "R8 init returns to input");
    for (int i = 0; i < 16; i++) toggle(1'b1, 1'b1);
    check(hist_o, 16'h5555, "R3 either edge pattern");
    reg_write(2'd0, 16'h0005);
    for (int i = 0; i < 32; i++) toggle(1'b1, 1'b0);
    check(hist_o, 16'hFFFF, "R3 rising only pattern");
    reg_write(2'd0, 16'h0006);
    for (int i = 0; i < 32; i++) toggle(1'b0, 1'b1);
    check(hist_o, 16'h0000, "R3 falling only pattern");
    reg_write(2'd0, 16'h0004);
    base = irq_cnt;
    for (int i = 0; i < 4; i++) toggle(1'b0, 1'b0);
    check(irq_cnt, base, "R3 edge select none");

    // R6 read request on the same edge as a rising edge
    reg_write(2'd0, 16'h0007);
    base = irq_cnt;
    expect_rec(1'b1);
    @(negedge clk); pin_in = 1'b1;
    @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 16'h000B;
    @(negedge clk); reg_wr = 1'b0;
    repeat (10) @(negedge clk);
    check(irq_cnt, base + 1, "R6 host request wins over edge");

    // R4 periodic mode
    reg_write(2'd0, 16'h0004);
    reg_write(2'd1, 16'd20);
    reg_read(2'd1, d);
    check(d, 16'd20, "R4 period readback");
    base = irq_cnt;
    expect_rec(1'b1); expect_rec(1'b1);
    issue(2'b11, 2'b01);
    wait_irq(base + 1);
    check(irq_last - irq_prev, 20, "R4 first match spacing");
    pin_in = 1'b0;
    expect_rec(1'b0);
    wait_irq(base + 2);
    check(irq_last - irq_prev, 20, "R4 second match spacing");
    expect_rec(1'b0);
    wait_irq(base + 3);
    check(irq_last - irq_prev, 20, "R4 third match spacing");

    // R8 to output with no init; matches stop
    expect_rec(1'b0); issue(2'b10, 2'b00);
    check(pin_oe, 1'b1, "R8 input to output by drive");
    base = irq_cnt;
    repeat (60) @(negedge clk);
    check(irq_cnt, base, "R8 no matches as output");

    // R10 reserved init
    d = hist_o;
    issue(2'b11, 2'b11);
    check(hist_o, d, "R10 history untouched");
    check(irq_cnt, base, "R10 no interrupt");
    check(pin_oe, 1'b1, "R10 direction untouched");

    // R7 interrupt disabled
    reg_write(2'd0, 16'h0000);
    issue(2'b01, 2'b00);
    model = {1'b1, model[15:1]};
    check(hist_o, model, "R7 recording without interrupt");
    check(irq_cnt, base, "R7 no pulse when disabled");

    repeat (5) @(negedge clk);
    check(exp_q.size(), 0, "R7 all expected records seen");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule